// File: doc/BRIEF.md
# Cipher Phase Sequencing Controller

This block steers the feedback-register input multiplexer of a stream cipher through its three phases. The phases are loading the key and IV, key initialization, and keystream running. It has one clock and one active-low synchronous reset, which the system asserts before every run. Its outputs are a 2-bit select code for the multiplexer, three phase flags, and a one-cycle pulse that marks the first running cycle, so that downstream logic knows when to start taking keystream.

The timing comes from an 11-stage one-hot ring. The ring starts rotating one cycle after reset is released, because a start register delays it. Each time the ring wraps back to its first stage, a phase counter advances. Phase counter values 1 and 2 both map to key initialization, so that phase lasts two ring revolutions. When the counter reaches the running value, the ring and the counter both stop until the next reset.

Top module: `cipher_phase_seq`

## Requirements
- R1: While `rst_n` is sampled low, the block shows the loading state on the following cycle: `sel` = 2'b00, `in_load` = 1, `in_init` = 0, `in_run` = 0, `run_start` = 0.
- R2: Take the first rising edge that samples `rst_n` high as edge 1. After edges 1 through 11, `sel` stays 2'b00 (loading). This span of 11 cycles includes the one-cycle start delay.
- R3: After edges 12 through 33, `sel` is 2'b01 (key initialization), which is 22 cycles.
- R4: From edge 34 onward, `sel` is 2'b10 (running), and it stays there for as long as `rst_n` stays high.
- R5: The code 2'b11 never appears on `sel`.
- R6: `run_start` is high for exactly one cycle, the first running cycle (after edge 34), and is low at all other times.
- R7: Exactly one of `in_load`, `in_init` and `in_run` is high at any time. That flag matches `sel`: 00 goes with load, 01 with init, 10 with run.
- R8: Asserting reset during loading, key initialization or running returns the block to the R1 state. The R2 to R6 timing then restarts from the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | output | 2 | Multiplexer select: 00 load, 01 init, 10 run |
| in_load | output | 1 | Loading phase flag |
| in_init | output | 1 | Key initialization phase flag |
| in_run | output | 1 | Running phase flag |
| run_start | output | 1 | One-cycle pulse on the first running cycle |

## Verification
The bench counts edges from reset release and tests both phase boundaries to the exact cycle. A design that skips the start register would leave loading one cycle early. A design that stops after one init revolution would enter running 11 cycles early. The bench holds the running phase for many cycles beyond the ring period. A design that lets the counter wrap would then emit code 11 or fall back to loading, and a missing freeze would give a second `run_start` pulse. The bench also reasserts reset inside each of the three phases and for a single cycle, which catches a start register or phase counter that fails to clear.

// File: rtl/cipher_seq_pkg.sv
package cipher_seq_pkg;

    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_INIT_A = 2'd1,
        PH_INIT_B = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_LOAD = 2'b00,
        SEL_INIT = 2'b01,
        SEL_RUN  = 2'b10
    } sel_e;

    typedef struct packed {
        logic load;
        logic init;
        logic run;
    } status_t;

    function automatic sel_e phase_to_sel(phase_e ph);
        case (ph)
            PH_LOAD:              return SEL_LOAD;
            PH_INIT_A, PH_INIT_B: return SEL_INIT;
            default:              return SEL_RUN;
        endcase
    endfunction

    function automatic status_t phase_to_status(phase_e ph);
        status_t s;
        s.load = (ph == PH_LOAD);
        s.init = (ph == PH_INIT_A) || (ph == PH_INIT_B);
        s.run  = (ph == PH_RUN);
        return s;
    endfunction

endpackage

// File: rtl/cipher_ring_ctr.sv
module cipher_ring_ctr #(
    parameter int LEN = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    output logic [LEN-1:0] ring,
    output logic           wrap
);
    localparam logic [LEN-1:0] HOME = {{(LEN-1){1'b0}}, 1'b1};

    logic [LEN-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_q <= HOME;
        else if (advance)
            ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
    end

    assign ring = ring_q;
    assign wrap = advance & ring_q[LEN-1];
endmodule

// File: rtl/cipher_phase_ctr.sv
module cipher_phase_ctr
    import cipher_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    output phase_e phase,
    output logic   first_run
);
    phase_e phase_q;
    logic   first_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOAD;
            first_q <= 1'b0;
        end else begin
            first_q <= step && (phase_q == PH_INIT_B);
            if (step && phase_q != PH_RUN)
                phase_q <= phase_e'(phase_q + 2'd1);
        end
    end

    assign phase     = phase_q;
    assign first_run = first_q;
endmodule

// File: rtl/cipher_phase_seq.sv
module cipher_phase_seq
    import cipher_seq_pkg::*;
#(
    parameter int RING_LEN = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] sel,
    output logic       in_load,
    output logic       in_init,
    output logic       in_run,
    output logic       run_start
);
    logic                go_q;
    logic                advance;
    logic                wrap;
    logic [RING_LEN-1:0] ring_q;
    phase_e              phase_q;
    status_t             stat;

    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= 1'b1;
    end

    assign advance = go_q && (phase_q != PH_RUN);

    cipher_ring_ctr #(.LEN(RING_LEN)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .ring    (ring_q),
        .wrap    (wrap)
    );

    cipher_phase_ctr u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (wrap),
        .phase     (phase_q),
        .first_run (run_start)
    );

    always_comb begin
        stat    = phase_to_status(phase_q);
        sel     = phase_to_sel(phase_q);
        in_load = stat.load;
        in_init = stat.init;
        in_run  = stat.run;
    end
endmodule

// File: rtl/cipher_phase_seq_chk.sv
module cipher_phase_seq_chk #(
    parameter int LEN = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic [LEN-1:0] ring,
    input logic [1:0]     phase,
    input logic [1:0]     sel,
    input logic           in_load,
    input logic           in_init,
    input logic           in_run,
    input logic           run_start
);
    // R5
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11);

    // R7
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({in_load, in_init, in_run}));

    // R2
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ring));

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_run |=> in_run && $stable(ring));

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> !run_start);

    // R6
    start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> in_run);

    // R3
    phase_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> $past(ring[LEN-1]));
endmodule

bind cipher_phase_seq cipher_phase_seq_chk #(.LEN(RING_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring      (ring_q),
    .phase     (phase_q),
    .sel       (sel),
    .in_load   (in_load),
    .in_init   (in_init),
    .in_run    (in_run),
    .run_start (run_start)
);

// File: tb/tb_cipher_phase_seq.sv
module tb_cipher_phase_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel;
    logic       in_load, in_init, in_run, run_start;

    int checks = 0;
    int errors = 0;
    int cnt = -1;          // edges since release, -1 while in reset
    bit restarted = 1'b0;  // set once a mid-sequence reset has occurred
    bit done = 1'b0;

    cipher_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .in_load(in_load), .in_init(in_init), .in_run(in_run),
        .run_start(run_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: count edges after release
    always @(posedge clk) begin
        if (!rst_n) cnt = -1;
        else if (cnt < 1000) cnt = cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cnt=%0d actual=%0d expected=%0d", req, cnt, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int exp_sel;
        string rq;
        if (!done && $time > 0) begin
            if (cnt < 0) begin
                rq = restarted ? "R8" : "R1";
                check(rq, sel, 0);
                check(rq, {in_load, in_init, in_run}, 3'b100);
                check(rq, run_start, 0);
            end else begin
                if (cnt < 11)      begin exp_sel = 0; rq = "R2"; end
                else if (cnt < 33) begin exp_sel = 1; rq = "R3"; end
                else               begin exp_sel = 2; rq = "R4"; end
                if (restarted) rq = {rq, "/R8"};
                check(rq, sel, exp_sel);
                check("R5", (sel == 2'b11), 0);
                check("R6", run_start, (cnt == 33));
                check("R7", {in_load, in_init, in_run},
                      exp_sel == 0 ? 3'b100 : exp_sel == 1 ? 3'b010 : 3'b001);
            end
        end
    end

    task automatic run_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        run_for(n);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        run_for(3);
        rst_n = 1'b1;
        run_for(80);           // full sequence plus long running hold
        restarted = 1'b1;
        do_reset(2);           // reset in running
        run_for(20);
        do_reset(2);           // reset during key initialization
        run_for(5);
        do_reset(1);           // single-cycle reset during loading
        run_for(60);
        do_reset(3);
        run_for(40);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule